// File: doc/BRIEF.md
# SPI Master Boot Stream Reader

After reset this block pulls a boot image out of a serial memory, or out of a host acting as an SPI slave, and hands it to on-chip memory one 32-bit word at a time. A one-cycle `start` pulse latches a word count. The block then lowers the active-low select and starts the serial clock. It shifts out a read command of 0x03 followed by an all-zero start address, whose width is a parameter of 8, 16 or 32 bits.

The block then keeps clocking and only receives. Incoming bits are packed into words with the first byte received in the lowest byte lane. Each completed word goes out on a write strobe, at an address that starts at zero and steps by one. When the counted number of words has arrived, the serial clock returns to its idle-high level and the select is released. A `done` pulse marks the end.

The serial interface runs in SPI mode 3, and every byte travels least-significant bit first. The serial clock period is `CLK_DIV` system clocks, which must be even and at least 2. Each serial bit period starts with `CLK_DIV/2` cycles low, followed by `CLK_DIV/2` cycles high.

Top module: `spi_boot_reader`

## Requirements
- R1: Out of reset, and on every cycle after a synchronous reset (including one applied mid-transfer), `sclk`=1, `cs_n`=1, `busy`=0, `wr_en`=0 and `done`=0; whenever `busy` is 0, `sclk` and `cs_n` are both 1.
- R2: A `start` pulse while idle makes `cs_n`=0 and `busy`=1 on the next cycle. Each serial bit period lasts `CLK_DIV` cycles, with `sclk` low for the first half and high for the second. `mosi` changes only on the cycle where `sclk` falls. A transfer of N words gives exactly 8+`ADDR_BITS`+32*N rising `sclk` edges.
- R3: The first 8 bits on `mosi`, taken at rising `sclk` edges, are the read command 0x03 sent least-significant bit first: wire order 1,1,0,0,0,0,0,0.
- R4: The next `ADDR_BITS` bits on `mosi` are all 0 (start address zero).
- R5: After the header, `miso` is captured at each rising `sclk` edge. Every 32 captured bits form one word. Stream byte k of a word (k=0..3, in arrival order) lands in `wr_data[8k+7:8k]`, and within a byte the first bit captured is the least-significant bit.
- R6: Each completed word raises `wr_en` for exactly one cycle. The `wr_addr` values in a transfer are 0, 1, 2 and so on, in order.
- R7: After the number of words latched from `word_count` at start have been written, the block finishes the final bit period. `done` then rises `CLK_DIV/2` cycles after the last `wr_en` and lasts one cycle, with `sclk`=1, `cs_n`=1 and `busy`=0. A count of 0 produces no writes: `done` follows the end of the header.
- R8: A `start` pulse while `busy` is 1 is ignored: the transfer continues, and its writes, addresses and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a boot fetch |
| word_count | input | CNT_W | Number of 32-bit words to fetch, latched at start |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Device select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| wr_en | output | 1 | One-cycle write strobe for a completed word |
| wr_addr | output | CNT_W | Word address of the write |
| wr_data | output | 32 | Assembled word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The select and the busy flag react one cycle after `start`. Each received bit is captured on the system edge where `sclk` rises, so a word's `wr_en` appears on that same edge as the 32nd rising edge of its group, and `done` trails the last write by `CLK_DIV/2` cycles. The bench's slave model reacts only after a rising serial edge, which gives the design a full serial period of stable `miso`. All outputs are sampled on falling system edges, and the write-to-done gap is measured against a free-running cycle counter. Header bits are captured at the same rising serial edges the design uses, and the bench compares them with the expected command and address once each transfer ends.

// File: rtl/spi_boot_reader.sv
module spi_boot_reader #(
  parameter int CLK_DIV   = 4,
  parameter int ADDR_BITS = 16,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] word_count,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic             busy,
  output logic             done
);
  localparam int HALF    = CLK_DIV / 2;
  localparam int DIV_W   = $clog2(CLK_DIV);
  localparam int TX_BITS = 8 + ADDR_BITS;
  localparam int BC_W    = $clog2((TX_BITS > 32) ? TX_BITS : 32);
  localparam logic [7:0]       READ_CMD  = 8'h03;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] SAMPLE_AT = DIV_W'(HALF - 1);
  localparam logic [DIV_W-1:0] RISE_AT   = DIV_W'(HALF);
  localparam logic [BC_W-1:0]  HDR_LAST  = BC_W'(TX_BITS - 1);
  localparam logic [BC_W-1:0]  WORD_LAST = BC_W'(31);

  logic             run_q, rx_q, last_q;
  logic [DIV_W-1:0] div_q;
  logic [BC_W-1:0]  bit_q;
  logic [CNT_W-1:0] words_q, cnt_q;
  logic [31:0]      sh_q;

  wire             div_end = (div_q == DIV_LAST);
  wire             sample  = rx_q && (div_q == SAMPLE_AT);
  wire [DIV_W-1:0] div_nxt = div_end ? '0 : div_q + 1'b1;

  assign busy = run_q;
  assign mosi = run_q && !rx_q && (bit_q < BC_W'(8)) && READ_CMD[bit_q[2:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      rx_q    <= 1'b0;
      last_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      words_q <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q   <= 1'b1;
          rx_q    <= 1'b0;
          last_q  <= 1'b0;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          div_q   <= '0;
          bit_q   <= '0;
          words_q <= '0;
          cnt_q   <= word_count;
        end
      end else begin
        div_q <= div_nxt;
        sclk  <= (div_nxt >= RISE_AT);
        if (!rx_q && div_end) begin
          if (bit_q == HDR_LAST) begin
            bit_q <= '0;
            rx_q  <= 1'b1;
            if (cnt_q == '0) begin
              run_q  <= 1'b0;
              rx_q   <= 1'b0;
              cs_n   <= 1'b1;
              sclk   <= 1'b1;
              done   <= 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        if (sample) begin
          sh_q <= {miso, sh_q[31:1]};
          if (bit_q == WORD_LAST) begin
            bit_q   <= '0;
            wr_en   <= 1'b1;
            wr_data <= {miso, sh_q[31:1]};
            wr_addr <= words_q;
            words_q <= words_q + 1'b1;
            if (words_q + 1'b1 == cnt_q) last_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        if (rx_q && div_end && last_q) begin
          run_q  <= 1'b0;
          rx_q   <= 1'b0;
          last_q <= 1'b0;
          cs_n   <= 1'b1;
          sclk   <= 1'b1;
          done   <= 1'b1;
        end
      end
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk && cs_n));

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cs_n && sclk));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (!cs_n || done));
endmodule

// File: tb/spi_boot_reader_test.sv
`timescale 1ns/1ps
module spi_boot_reader_test;
  localparam int DIV  = 4;
  localparam int AB   = 16;
  localparam int CW   = 16;
  localparam int TXB  = 8 + AB;
  localparam int HALF = DIV / 2;
  localparam logic [15:0] VEC [5] = '{16'h0111, 16'h0322, 16'h0033, 16'h0244, 16'h0555};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, miso = 1'b0;
  logic [CW-1:0] wcount = '0;
  logic sclk, cs_n, mosi, wr_en, busy, done;
  logic [CW-1:0] wr_addr;
  logic [31:0] wr_data;

  spi_boot_reader #(.CLK_DIV(DIV), .ADDR_BITS(AB), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .word_count(wcount),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] img_byte(input int seed, input int idx);
    return 8'((idx * 29 + seed * 7 + 1) ^ (idx << 4));
  endfunction

  int sk = 0, sseed = 0, sn;
  logic [7:0] sb;
  logic [TXB-1:0] hdr;
  always @(posedge sclk) begin
    if (!cs_n) begin
      if (sk < TXB) hdr[sk] = mosi;
      if (sk >= TXB - 1) begin
        sn = sk + 1 - TXB;
        sb = img_byte(sseed, sn / 8);
        miso = sb[sn % 8];
      end
      sk++;
    end
  end

  int wr_seen = 0, last_wr_cyc = 0;
  bit prev_wr = 0;
  logic [31:0] expw;
  always @(negedge clk) begin
    if (wr_en) begin
      expw = {img_byte(sseed, 4*wr_seen+3), img_byte(sseed, 4*wr_seen+2),
              img_byte(sseed, 4*wr_seen+1), img_byte(sseed, 4*wr_seen)};
      chk(wr_addr == CW'(wr_seen), "R6", "write address", longint'(wr_addr), longint'(wr_seen));
      chk(wr_data == expw, "R5", "write data", longint'(wr_data), longint'(expw));
      chk(!prev_wr, "R6", "strobe width", 64'd2, 64'd1);
      wr_seen++;
      last_wr_cyc = cyc;
    end
    prev_wr = wr_en;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic run(input int count, input int seed, input bit poke);
    int t;
    @(negedge clk);
    sk = 0; sseed = seed; wr_seen = 0; hdr = '1;
    wcount = CW'(count); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R2", "select after start", longint'({cs_n, busy}), 64'h1);
    if (poke) begin
      repeat (TXB * DIV + 10) @(negedge clk);
      wcount = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R7", "done seen", longint'(done), 64'd1);
    chk(hdr[7:0] == 8'h03, "R3", "command bits", longint'(hdr[7:0]), 64'h03);
    chk(hdr[TXB-1:8] == '0, "R4", "address bits", longint'(hdr[TXB-1:8]), 64'h0);
    chk(wr_seen == count, (poke ? "R8" : "R7"), "word total", longint'(wr_seen), longint'(count));
    chk(sk == TXB + 32 * count, "R2", "rising edges", longint'(sk), longint'(TXB + 32 * count));
    chk(cs_n && sclk && !busy, "R7", "lines at done", longint'({cs_n, sclk, busy}), 64'h6);
    if (count > 0)
      chk(cyc - last_wr_cyc == HALF, "R7", "write to done gap",
          longint'(cyc - last_wr_cyc), longint'(HALF));
    @(negedge clk);
    chk(!done, "R7", "done width", longint'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk && cs_n && !busy && !wr_en && !done, "R1", "reset state",
        longint'({sclk, cs_n, busy, wr_en, done}), 64'h18);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk && cs_n && !busy, "R1", "idle after reset", longint'({sclk, cs_n, busy}), 64'h6);

    for (int i = 0; i < 5; i++)
      run(int'(VEC[i][15:8]), int'(VEC[i][7:0]), i == 3);

    @(negedge clk);
    sk = 0; sseed = 9; wr_seen = 0;
    wcount = CW'(4); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    begin
      bit bad = 0;
      for (int k = 0; k < 300; k++) begin
        if (!(sclk && cs_n && !busy && !done && !wr_en)) bad = 1;
        @(negedge clk);
      end
      chk(!bad, "R1", "idle after mid-transfer reset", longint'(bad), 64'd0);
    end

    run(1, 77, 1'b0);
    summary();
  end
endmodule